// File: doc/BRIEF.md
# Interval Timer Peripheral

This block is a bus slave that keeps a free-running 64-bit cycle counter and can raise interrupt pulses after a programmable 64-bit number of cycles. Software reads the counter in two 32-bit halves to measure elapsed time. It programs a delay and picks one of three modes: off, a limited number of interrupts, or interrupts that repeat until the mode is changed. Each interrupt also re-arms the timer by taking a snapshot of the counter, so the next interrupt follows one delay later.

The bus side is a plain request slave. A request is a single-cycle strobe with a write enable, a byte offset and write data. The block answers every request with `ready` in the next cycle, so it never applies back-pressure. Read data comes from a register and is valid while `ready` is high. The interrupt line carries a one-cycle pulse and has no acknowledge input. If the core is busy when a pulse arrives, that pulse is lost, and the timer keeps counting toward the next one. A write of 1 to the reset offset returns every register to its reset value without touching the hardware reset.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter is 0 and increases by one on every clock edge. A read at offset 0x00 returns bits 31:0 and a read at offset 0x04 returns bits 63:32 of the value the counter held in the request cycle.
- R2: The delay is readable and writable, with bits 31:0 at offset 0x08 and bits 63:32 at offset 0x0C. It changes only on reset or on a bus write to one of those offsets.
- R3: The mode register is at offset 0x10 and uses the encodings 0 = off, 1 = counted, 2 = continuous. A write of any value above 2 leaves the mode unchanged.
- R4: The repetition count is readable and writable at offset 0x14.
- R5: The interrupt is high while the mode is not off and the snapshot plus the delay equals the counter. A write of a non-off mode loads the snapshot with the counter value of the write cycle, so the first pulse arrives `delay` cycles after that value. With a delay of 2 or more, each pulse lasts exactly one cycle.
- R6: In continuous mode each pulse reloads the snapshot, so pulses repeat every `delay` cycles until the mode is written to off.
- R7: In counted mode each pulse decrements a nonzero repetition count. The pulse that finds the count at 1 or 0 sets the mode to off and leaves the snapshot unchanged, so a count of N ≥ 1 gives exactly N pulses.
- R8: `ready` is high in the cycle after each request and low in all other cycles. Read data is registered and valid while `ready` is high.
- R9: Reads of unmapped offsets return 0. Writes to the counter offsets or to unmapped offsets have no effect.
- R10: A write of 1 to offset 0x24 clears the counter, delay, mode, repetition count and snapshot.
- R11: While the hardware reset is active, `ready`, `irq_o` and the read data are 0 and every register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe, one cycle per access |
| we_i | input | 1 | Write enable for the request (1 = write) |
| addr_i | input | ADDR_W (8) | Byte offset within the peripheral |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| ready_o | output | 1 | Access done; high the cycle after a request |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that requests are single-cycle strobes and that the single-pulse property applies only when the delay is at least 2. A delay of 0 never fires after re-arming, and a delay of 1 fires on every cycle. The stimulus always uses delays of 8 or more and keeps each access one cycle long, with an idle cycle between accesses. It changes the mode only while no pulse is due, so a mode write never lands in the same cycle as a pulse. Expected counter reads are computed from cycles counted in the bench since the last hardware or software reset.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_COUNTED = 2'd1,
    MODE_CONT    = 2'd2
  } tmode_e;

  localparam int unsigned OFS_CNT_LO = 'h00;
  localparam int unsigned OFS_CNT_HI = 'h04;
  localparam int unsigned OFS_DLY_LO = 'h08;
  localparam int unsigned OFS_DLY_HI = 'h0C;
  localparam int unsigned OFS_MODE   = 'h10;
  localparam int unsigned OFS_REP    = 'h14;
  localparam int unsigned OFS_SRST   = 'h24;
endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_q <= '0;
    else if (clr_i) count_q <= '0;
    else            count_q <= count_q + CNT_W'(1);
  end

  assign count_o = count_q;

  // R1: one step per cycle unless cleared
  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> count_o == $past(count_o) + CNT_W'(1));
  // R10: software reset restarts the count
  a_r10_count_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);
endmodule

// File: rtl/itmr_bus.sv
module itmr_bus
  import itmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  tmode_e            mode_i,
  input  logic [DATA_W-1:0] rep_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic [CNT_W-1:0]  delay_o,
  output logic              clr_o,
  output logic              mode_wr_o,
  output logic              rep_wr_o
);
  logic              wr, rd;
  logic              dly_lo_wr, dly_hi_wr;
  logic [CNT_W-1:0]  delay_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              ready_q;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  assign dly_lo_wr = wr && (addr_i == ADDR_W'(OFS_DLY_LO));
  assign dly_hi_wr = wr && (addr_i == ADDR_W'(OFS_DLY_HI));
  assign mode_wr_o = wr && (addr_i == ADDR_W'(OFS_MODE));
  assign rep_wr_o  = wr && (addr_i == ADDR_W'(OFS_REP));
  assign clr_o     = wr && (addr_i == ADDR_W'(OFS_SRST)) && (wdata_i == DATA_W'(1));

  always_comb begin
    rd_mux = '0;
    if      (addr_i == ADDR_W'(OFS_CNT_LO)) rd_mux = count_i[DATA_W-1:0];
    else if (addr_i == ADDR_W'(OFS_CNT_HI)) rd_mux = count_i[CNT_W-1:DATA_W];
    else if (addr_i == ADDR_W'(OFS_DLY_LO)) rd_mux = delay_q[DATA_W-1:0];
    else if (addr_i == ADDR_W'(OFS_DLY_HI)) rd_mux = delay_q[CNT_W-1:DATA_W];
    else if (addr_i == ADDR_W'(OFS_MODE))   rd_mux = DATA_W'(mode_i);
    else if (addr_i == ADDR_W'(OFS_REP))    rd_mux = rep_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delay_q <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= req_i;
      if (rd) rdata_q <= rd_mux;
      if (clr_o) delay_q <= '0;
      else begin
        if (dly_lo_wr) delay_q[DATA_W-1:0]     <= wdata_i;
        if (dly_hi_wr) delay_q[CNT_W-1:DATA_W] <= wdata_i;
      end
    end
  end

  assign delay_o = delay_q;
  assign rdata_o = rdata_q;
  assign ready_o = ready_q;

  // R8: answer exactly one cycle after each request
  a_r8_ready_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);
  a_r8_no_stray_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);
  // R2: delay holds without a write or clear
  a_r2_delay_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dly_lo_wr || dly_hi_wr || clr_o) |=> $stable(delay_o));
endmodule

// File: rtl/itmr_engine.sv
module itmr_engine
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              mode_wr_i,
  input  logic              rep_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  delay_i,
  output tmode_e            mode_o,
  output logic [DATA_W-1:0] rep_o,
  output logic              irq_o
);
  tmode_e            mode_q;
  logic [DATA_W-1:0] rep_q;
  logic [CNT_W-1:0]  snap_q;
  logic              fire, last;

  assign fire = (mode_q != MODE_OFF) && (snap_q + delay_i == count_i);
  assign last = (mode_q == MODE_COUNTED) && (rep_q <= DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      rep_q  <= '0;
      snap_q <= '0;
    end else if (clr_i) begin
      mode_q <= MODE_OFF;
      rep_q  <= '0;
      snap_q <= '0;
    end else begin
      if (mode_wr_i) begin
        if (wdata_i == DATA_W'(MODE_OFF)) begin
          mode_q <= MODE_OFF;
        end else if (wdata_i == DATA_W'(MODE_COUNTED)) begin
          mode_q <= MODE_COUNTED;
          snap_q <= count_i;
        end else if (wdata_i == DATA_W'(MODE_CONT)) begin
          mode_q <= MODE_CONT;
          snap_q <= count_i;
        end
      end else if (fire) begin
        if (last) mode_q <= MODE_OFF;
        else      snap_q <= count_i;
      end
      if (rep_wr_i) rep_q <= wdata_i;
      else if (fire && mode_q == MODE_COUNTED && rep_q != '0) rep_q <= rep_q - DATA_W'(1);
    end
  end

  assign mode_o = mode_q;
  assign rep_o  = rep_q;
  assign irq_o  = fire;

  // R5: a pulse is a single cycle when the delay is at least 2
  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && delay_i >= CNT_W'(2) |=> (!irq_o || delay_i < CNT_W'(2)));
  // R3: out-of-range mode codes are dropped
  a_r3_bad_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && wdata_i > DATA_W'(2) && !clr_i |=> $stable(mode_o));
  // R7: the final counted pulse turns the timer off
  a_r7_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && last && !mode_wr_i && !clr_i |=> mode_o == MODE_OFF);
  // R7: each counted pulse consumes one repetition
  a_r7_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && mode_o == MODE_COUNTED && rep_o != '0 && !rep_wr_i && !clr_i
    |=> rep_o == $past(rep_o) - DATA_W'(1));
  // R11: no pulse while off
  a_r11_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_OFF |-> !irq_o);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  count, delay;
  logic              clr, mode_wr, rep_wr;
  tmode_e            mode;
  logic [DATA_W-1:0] rep;

  itmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .count_o(count)
  );

  itmr_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .count_i(count), .mode_i(mode),
    .rep_i(rep), .rdata_o(rdata_o), .ready_o(ready_o), .delay_o(delay),
    .clr_o(clr), .mode_wr_o(mode_wr), .rep_wr_o(rep_wr)
  );

  itmr_engine #(.DATA_W(DATA_W)) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .mode_wr_i(mode_wr),
    .rep_wr_i(rep_wr), .wdata_i(wdata_i), .count_i(count), .delay_i(delay),
    .mode_o(mode), .rep_o(rep), .irq_o(irq_o)
  );
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, irq;

  int total = 0, bad = 0;
  bit done = 0;
  longint unsigned cyc = 0, mark = 0, last_edge = 0;
  logic [31:0] exp_q[$];
  bit          chk_q[$];
  int          req_q[$];
  longint unsigned irq_t[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  interval_timer i_interval_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .irq_o(irq)
  );

  task automatic check(bit ok, int r, longint unsigned act, longint unsigned expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=%0d expected=%0d", r, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every ready, logs interrupt pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_t.push_back(cyc);
      if (exp_q.size() != 0 && !ready) check(0, 8, 0, 1);  // R8 late ready
      if (ready) begin
        if (exp_q.size() == 0) check(0, 8, 1, 0);          // R8 stray ready
        else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic bit c = chk_q.pop_front();
          automatic int r = req_q.pop_front();
          if (c) check(rdata == e, r, rdata, e);
        end
      end
    end
  end

  task automatic access(bit w, logic [7:0] a, logic [31:0] d, bit c, logic [31:0] e, int r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    last_edge = cyc;
    exp_q.push_back(e); chk_q.push_back(c); req_q.push_back(r);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    access(1, a, d, 0, '0, 8);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, int r);
    access(0, a, '0, 1, e, r);
  endtask

  // counter read: expected is the count held in the request cycle
  task automatic rd_cnt(bit hi, int r);
    longint unsigned v;
    @(negedge clk);
    v = cyc - mark;
    req = 1'b1; we = 1'b0; addr = hi ? 8'h04 : 8'h00;
    @(posedge clk); #1;
    exp_q.push_back(hi ? v[63:32] : v[31:0]); chk_q.push_back(1); req_q.push_back(r);
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    check(0, 0, 0, 1);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint unsigned e;
    repeat (3) @(negedge clk);
    // R11: quiet outputs during reset
    check(ready == 0, 11, ready, 0);
    check(irq == 0, 11, irq, 0);
    check(rdata == 0, 11, rdata, 0);
    @(posedge clk); #1; mark = cyc;
    @(negedge clk); rst_n = 1'b1;

    // R11 / R2 / R3 / R4: cleared registers
    rd(8'h08, 0, 11); rd(8'h0C, 0, 11); rd(8'h10, 0, 11); rd(8'h14, 0, 11);
    // R1: counter halves
    rd_cnt(0, 1); repeat (7) @(posedge clk); rd_cnt(0, 1); rd_cnt(1, 1);
    // R2: delay round trip
    wr(8'h08, 32'hDEAD_BEEF); wr(8'h0C, 32'h0000_0055);
    rd(8'h08, 32'hDEAD_BEEF, 2); rd(8'h0C, 32'h55, 2);
    // R4: repetition count round trip
    wr(8'h14, 32'h1234_5678); rd(8'h14, 32'h1234_5678, 4);
    // R9: unmapped reads and ignored writes
    rd(8'h18, 0, 9); rd(8'h24, 0, 9);
    wr(8'h00, 32'd999); wr(8'h30, 32'd7); rd_cnt(0, 9);
    // R3: bad mode code ignored (delay far off, no pulses)
    wr(8'h10, 32'd1); wr(8'h10, 32'd3); rd(8'h10, 32'd1, 3);
    wr(8'h10, 32'd0); rd(8'h10, 32'd0, 3);

    // R5 / R6: continuous mode, delay 10
    wr(8'h0C, 0); wr(8'h08, 32'd10);
    irq_t.delete();
    wr(8'h10, 32'd2); e = last_edge;
    repeat (35) @(posedge clk);
    wr(8'h10, 32'd0);
    check(irq_t.size() == 3, 6, irq_t.size(), 3);
    for (int i = 0; i < 3 && i < irq_t.size(); i++)
      check(irq_t[i] == e + 9 + 10 * i, (i == 0) ? 5 : 6, irq_t[i], e + 9 + 10 * i);
    rd(8'h08, 32'd10, 2);

    // R7: counted mode, 3 repetitions, delay 8
    wr(8'h14, 32'd3); wr(8'h08, 32'd8);
    irq_t.delete();
    wr(8'h10, 32'd1); e = last_edge;
    repeat (40) @(posedge clk);
    check(irq_t.size() == 3, 7, irq_t.size(), 3);
    for (int i = 0; i < 3 && i < irq_t.size(); i++)
      check(irq_t[i] == e + 7 + 8 * i, 7, irq_t[i], e + 7 + 8 * i);
    rd(8'h10, 32'd0, 7); rd(8'h14, 32'd0, 7);

    // R10: software reset; a value other than 1 does nothing
    wr(8'h14, 32'd9); wr(8'h24, 32'd2); rd(8'h14, 32'd9, 10);
    wr(8'h10, 32'd2);
    wr(8'h24, 32'd1); mark = last_edge;
    rd(8'h08, 0, 10); rd(8'h10, 0, 10); rd(8'h14, 0, 10);
    rd_cnt(0, 10); rd_cnt(1, 10);
    irq_t.delete();
    repeat (20) @(posedge clk);
    check(irq_t.size() == 0, 10, irq_t.size(), 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, 8, exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule